// File: doc/BRIEF.md
# Oversampled Majority-Vote UART Receiver

This block recovers bytes from an asynchronous serial line. Its clock runs at a fixed multiple of the bit rate, and that multiple is chosen at run time as 8, 16 or 32. The line first passes through a two-stage synchronizer. The block then waits for the line to fall from its idle high level. Once the line falls, a per-bit counter sets the timing of the whole frame.

Each bit is decided from three samples taken around its centre, and a majority vote over those samples gives the bit value. The block collects eight data bits, least significant first. If enabled, it checks a parity bit of selectable sense. It then checks the stop bit. A clean frame produces a one-cycle valid strobe together with the byte. A frame with a bad parity bit or a bad stop bit produces a one-cycle error strobe instead, and the last good byte stays on the output.

Top module: `uart_vote_rx`

## Requirements
- R1: A synchronous active-high `rst` sets `rx_data` to 0, clears `rx_valid`, `par_err` and `stop_err`, and returns the receiver to idle. This holds even when reset arrives in the middle of a frame. A clean frame sent after reset is then received normally.
- R2: The line idles high. The receiver passes the line through two flip-flops. A frame starts on the first high-to-low transition of that synchronized line seen while the receiver is idle.
- R3: `ratio_sel` sets the clock cycles per bit, P. The encoding is 0 → 8, 1 → 16, and 2 or 3 → 32. It is captured when the start edge is detected, so a change to `ratio_sel` during a frame has no effect on that frame. `par_en` and `par_odd` are captured at the same moment.
- R4: Counting the first cycle of each bit as 0, the bit is sampled at cycles P/2-1, P/2 and P/2+1, and its value is the majority of the three samples. A flip of a single cycle at cycle P/2 leaves the bit unchanged. A flip covering cycles P/2-1 and P/2 inverts the bit.
- R5: If the voted start bit is 1, the frame is treated as noise. The receiver returns to idle and produces no strobe, and `rx_data` does not change.
- R6: Eight data bits follow the start bit. The i-th data bit after the start bit becomes `rx_data[i]`.
- R7: With `par_en`=1, one parity bit follows the data bits. Its expected value is the XOR of the eight data bits when `par_odd`=0, and the inverse of that XOR when `par_odd`=1. On a mismatch, `par_err` is high for one cycle and `rx_valid` stays low. With `par_en`=0 there is no parity bit and `par_err` stays low.
- R8: A voted stop bit of 0 drives `stop_err` high for one cycle and keeps `rx_valid` low. `rx_valid` is never high in the same cycle as either error flag.
- R9: On a clean frame, `rx_valid` is high for exactly one cycle, and `rx_data` takes the new byte in that cycle. `rx_data` then holds its value until the next clean frame; frames with errors do not change it.
- R10: The receiver is back in idle by the last cycle of the stop bit. A start bit that immediately follows a stop bit, with no idle time between frames, is therefore received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock, P times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| ratio_sel | input | 2 | Oversampling select: 0=8, 1=16, 2/3=32 |
| par_en | input | 1 | 1 = a parity bit follows the data |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rx_data | output | 8 | Last byte received without error |
| rx_valid | output | 1 | One-cycle strobe for a clean frame |
| par_err | output | 1 | One-cycle strobe for a parity mismatch |
| stop_err | output | 1 | One-cycle strobe for a low stop bit |

## Verification
The bench places short flips inside a bit to test the sampling and voting. A one-cycle flip at the bit centre must be outvoted, while a two-cycle flip must invert the bit. A receiver that samples only once, or at the wrong offsets, gets one of these two cases wrong. A start pulse that returns high before the centre of the bit must leave no trace on the outputs; a design that skips the start vote would instead decode a frame of noise. Further tests send frames with no gap between them and change `ratio_sel` during a frame. A design that returns to idle late drops the second frame, and one that does not hold the captured ratio decodes the first frame with the wrong timing. The remaining tests cover bad parity, bad stop bits and a reset during a frame. For each of them the bench checks that `rx_data` keeps the last good byte and that every strobe lasts one cycle.

// File: rtl/uart_vote_rx_pkg.sv
package uart_vote_rx_pkg;

  localparam int unsigned MAX_RATIO = 32;
  localparam int unsigned VOTE_TAPS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_t;

  // Convert the ratio select code into clock cycles per bit.
  function automatic int unsigned ratio_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic majority3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

endpackage

// File: rtl/uart_vote_rx_sync.sv
module uart_vote_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], din};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign dout = chain_q[STAGES-1];
  assign fall = prev_q & ~chain_q[STAGES-1];

  // A falling edge always follows a cycle in which the synchronized line was high.
  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    fall |-> $past(dout)); // R2

endmodule

// File: rtl/uart_vote_rx_bit_timer.sv
module uart_vote_rx_bit_timer
  import uart_vote_rx_pkg::*;
#(
  parameter int unsigned CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       active,
  input  logic [1:0] ratio_sel,
  input  logic       line,
  output logic       bit_end,
  output logic       vote
);

  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     last_q;
  logic [CNT_W-1:0]     mid;
  logic [VOTE_TAPS-1:0] smp;

  // Cycle 0 of the start bit is the cycle in which the edge is seen, so the count resumes at 1.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      last_q <= CNT_W'(ratio_of(2'd0) - 1);
    end else if (start) begin
      cnt_q  <= CNT_W'(1);
      last_q <= CNT_W'(ratio_of(ratio_sel) - 1);
    end else if (active) begin
      if (cnt_q == last_q) cnt_q <= '0;
      else                 cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign mid = (last_q >> 1) + CNT_W'(1);

  for (genvar k = 0; k < VOTE_TAPS; k++) begin : g_tap
    logic             tap_q;
    logic [CNT_W-1:0] pos;
    assign pos = mid + CNT_W'(k) - CNT_W'(1);
    always_ff @(posedge clk) begin
      if (rst)                        tap_q <= 1'b1;
      else if (active && cnt_q == pos) tap_q <= line;
    end
    assign smp[k] = tap_q;
  end

  assign bit_end = active && (cnt_q == last_q);
  assign vote    = majority3(smp);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_q); // R3
  AST_START_COUNT: assert property (@(posedge clk) disable iff (rst)
    start |=> cnt_q == CNT_W'(1)); // R4
  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (rst)
    (active && !start) |=> $stable(last_q)); // R3

endmodule

// File: rtl/uart_vote_rx_frame_ctrl.sv
module uart_vote_rx_frame_ctrl
  import uart_vote_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fall,
  input  logic                 bit_end,
  input  logic                 vote,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic                 start,
  output logic                 active,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 par_err,
  output logic                 stop_err
);

  localparam int unsigned IDX_W = $clog2(DATA_BITS);

  rx_state_t            state_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 par_bit_q;
  logic                 cfg_pen_q;
  logic                 cfg_podd_q;
  logic                 par_bad;
  logic                 stop_bad;

  assign start    = (state_q == ST_IDLE) && fall;
  assign active   = (state_q != ST_IDLE);
  assign par_bad  = cfg_pen_q && (par_bit_q != ((^shift_q) ^ cfg_podd_q));
  assign stop_bad = ~vote;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      shift_q    <= '0;
      par_bit_q  <= 1'b0;
      cfg_pen_q  <= 1'b0;
      cfg_podd_q <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      par_err    <= 1'b0;
      stop_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      stop_err <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (fall) begin
            state_q    <= ST_START;
            cfg_pen_q  <= par_en;
            cfg_podd_q <= par_odd;
          end
        end
        ST_START: begin
          if (bit_end) begin
            idx_q   <= '0;
            state_q <= vote ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (bit_end) begin
            shift_q <= {vote, shift_q[DATA_BITS-1:1]};
            if (idx_q == IDX_W'(DATA_BITS - 1))
              state_q <= cfg_pen_q ? ST_PARITY : ST_STOP;
            else
              idx_q <= idx_q + IDX_W'(1);
          end
        end
        ST_PARITY: begin
          if (bit_end) begin
            par_bit_q <= vote;
            state_q   <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (bit_end) begin
            state_q  <= ST_IDLE;
            par_err  <= par_bad;
            stop_err <= stop_bad;
            if (!par_bad && !stop_bad) begin
              rx_valid <= 1'b1;
              rx_data  <= shift_q;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R9
  AST_VALID_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!par_err && !stop_err)); // R8
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> $stable(rx_data)); // R9
  AST_NOISE_START: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && bit_end && vote) |=> (state_q == ST_IDLE && !rx_valid)); // R5
  AST_PAR_OFF: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PARITY) |-> cfg_pen_q); // R7

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
  import uart_vote_rx_pkg::*;
#(
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = $clog2(MAX_RATIO)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_line,
  input  logic [1:0]           ratio_sel,
  input  logic                 par_en,
  input  logic                 par_odd,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 par_err,
  output logic                 stop_err
);

  logic line_s;
  logic line_fall;
  logic start;
  logic active;
  logic bit_end;
  logic vote;

  uart_vote_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (rx_line),
    .dout (line_s),
    .fall (line_fall)
  );

  uart_vote_rx_bit_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .active    (active),
    .ratio_sel (ratio_sel),
    .line      (line_s),
    .bit_end   (bit_end),
    .vote      (vote)
  );

  uart_vote_rx_frame_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .fall     (line_fall),
    .bit_end  (bit_end),
    .vote     (vote),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .start    (start),
    .active   (active),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .par_err  (par_err),
    .stop_err (stop_err)
  );

endmodule

// File: tb/uart_vote_rx_tb_top.sv
module uart_vote_rx_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic [1:0] ratio_sel = 2'd1;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       par_err;
  logic       stop_err;

  int checks = 0;
  int errors = 0;
  int n_valid = 0, n_long = 0, n_perr = 0, n_serr = 0;
  int b_valid, b_perr, b_serr;
  logic prev_v = 1'b0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  uart_vote_rx dut_i (
    .clk(clk), .rst(rst), .rx_line(rx_line), .ratio_sel(ratio_sel),
    .par_en(par_en), .par_odd(par_odd), .rx_data(rx_data),
    .rx_valid(rx_valid), .par_err(par_err), .stop_err(stop_err)
  );

  always @(negedge clk) begin
    if (rst) prev_v = 1'b0;
    else begin
      if (rx_valid) begin
        n_valid++;
        if (prev_v) n_long++;
      end
      if (par_err)  n_perr++;
      if (stop_err) n_serr++;
      prev_v = rx_valid;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int p_of(input logic [1:0] s);
    return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
  endfunction

  task automatic snap();
    b_valid = n_valid; b_perr = n_perr; b_serr = n_serr;
  endtask

  // Drive one bit for p cycles; cycles [fat, fat+flen) carry the inverted level.
  task automatic send_bit(input logic v, input int p, input int fat, input int flen);
    for (int c = 0; c < p; c++) begin
      rx_line = (c >= fat && c < fat + flen) ? ~v : v;
      @(negedge clk);
    end
  endtask

  // Bit index: 0 start, 1..8 data, 9 parity, 10 stop.
  task automatic send_frame(input logic [7:0] d, input logic pflip, input logic stop_v,
                            input int gbit, input int gat, input int glen, input int new_sel);
    int   p;
    logic pb;
    p  = p_of(ratio_sel);
    pb = (^d) ^ par_odd ^ pflip;
    send_bit(1'b0, p, (gbit == 0) ? gat : 0, (gbit == 0) ? glen : 0);
    for (int i = 0; i < 8; i++) begin
      send_bit(d[i], p, (gbit == i + 1) ? gat : 0, (gbit == i + 1) ? glen : 0);
      if (i == 0 && new_sel >= 0) ratio_sel = 2'(new_sel);
    end
    if (par_en) send_bit(pb, p, 0, 0);
    send_bit(stop_v, p, 0, 0);
    rx_line = 1'b1;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input int dv, input int dp, input int ds,
                            input logic [7:0] dexp);
    chk({req, " valid strobes"}, n_valid - b_valid, dv);
    chk({req, " parity strobes"}, n_perr - b_perr, dp);
    chk({req, " stop strobes"}, n_serr - b_serr, ds);
    chk({req, " rx_data"}, int'(rx_data), int'(dexp));
  endtask

  task automatic t_reset();
    chk("R1 rx_data after reset", int'(rx_data), 0);
    chk("R1 strobes low after reset", int'({rx_valid, par_err, stop_err}), 0);
    snap();
    repeat (40) @(negedge clk);
    expect_out("R2 idle line gives no frame", 0, 0, 0, 8'h00);
  endtask

  task automatic t_basic();
    ratio_sel = 2'd1; par_en = 1'b0;
    snap(); send_frame(8'hA5, 0, 1, -1, 0, 0, -1); settle();
    expect_out("R6 R2 byte A5 at P=16", 1, 0, 0, 8'hA5);
    snap(); send_frame(8'h3C, 0, 1, -1, 0, 0, -1); settle();
    expect_out("R6 byte 3C at P=16", 1, 0, 0, 8'h3C);
  endtask

  task automatic t_ratios();
    ratio_sel = 2'd0;
    snap(); send_frame(8'h81, 0, 1, -1, 0, 0, -1); settle();
    expect_out("R3 P=8", 1, 0, 0, 8'h81);
    ratio_sel = 2'd2;
    snap(); send_frame(8'h5E, 0, 1, -1, 0, 0, -1); settle();
    expect_out("R3 P=32 code 2", 1, 0, 0, 8'h5E);
    ratio_sel = 2'd3;
    snap(); send_frame(8'hC7, 0, 1, -1, 0, 0, -1); settle();
    expect_out("R3 P=32 code 3", 1, 0, 0, 8'hC7);
  endtask

  task automatic t_sel_mid();
    ratio_sel = 2'd0;
    snap(); send_frame(8'h69, 0, 1, -1, 0, 0, 2); settle();
    expect_out("R3 select change mid-frame ignored", 1, 0, 0, 8'h69);
  endtask

  task automatic t_parity();
    ratio_sel = 2'd1; par_en = 1'b1;
    par_odd = 1'b0;
    snap(); send_frame(8'h13, 0, 1, -1, 0, 0, -1); settle();
    expect_out("R7 even parity good", 1, 0, 0, 8'h13);
    par_odd = 1'b1;
    snap(); send_frame(8'hF0, 0, 1, -1, 0, 0, -1); settle();
    expect_out("R7 odd parity good", 1, 0, 0, 8'hF0);
    par_odd = 1'b0;
    snap(); send_frame(8'h77, 1, 1, -1, 0, 0, -1); settle();
    expect_out("R7 R9 even parity bad keeps data", 0, 1, 0, 8'hF0);
    par_odd = 1'b1;
    snap(); send_frame(8'h01, 1, 1, -1, 0, 0, -1); settle();
    expect_out("R7 odd parity bad", 0, 1, 0, 8'hF0);
    par_en = 1'b0; par_odd = 1'b0;
  endtask

  task automatic t_stop();
    ratio_sel = 2'd0;
    snap(); send_frame(8'h2D, 0, 0, -1, 0, 0, -1);
    rx_line = 1'b1; repeat (40) @(negedge clk);
    expect_out("R8 low stop bit", 0, 0, 1, 8'hF0);
  endtask

  task automatic t_vote();
    ratio_sel = 2'd1;
    snap(); send_frame(8'h55, 0, 1, 3, 8, 1, -1); settle();
    expect_out("R4 one-cycle flip at centre outvoted", 1, 0, 0, 8'h55);
    snap(); send_frame(8'h55, 0, 1, 3, 7, 2, -1); settle();
    expect_out("R4 two-cycle flip inverts bit", 1, 0, 0, 8'h51);
    ratio_sel = 2'd0;
    snap(); send_frame(8'hAA, 0, 1, 2, 5, 1, -1); settle();
    expect_out("R4 flip at late tap outvoted P=8", 1, 0, 0, 8'hAA);
  endtask

  task automatic t_noise_start();
    ratio_sel = 2'd1;
    snap();
    send_bit(1'b0, 16, 2, 14);
    rx_line = 1'b1; repeat (30) @(negedge clk);
    expect_out("R5 short low pulse rejected", 0, 0, 0, 8'hAA);
    snap(); send_frame(8'h9C, 0, 1, -1, 0, 0, -1); settle();
    expect_out("R5 frame after rejected start", 1, 0, 0, 8'h9C);
  endtask

  task automatic t_back2back();
    ratio_sel = 2'd0;
    snap();
    send_frame(8'h11, 0, 1, -1, 0, 0, -1);
    send_frame(8'hEE, 0, 1, -1, 0, 0, -1);
    settle();
    expect_out("R10 frames with no gap", 2, 0, 0, 8'hEE);
    chk("R9 valid never longer than one cycle", n_long, 0);
  endtask

  task automatic t_reset_mid();
    ratio_sel = 2'd1;
    send_bit(1'b0, 16, 0, 0);
    send_bit(1'b1, 16, 0, 0);
    send_bit(1'b0, 8, 0, 0);
    rst = 1'b1; rx_line = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 rx_data cleared by mid-frame reset", int'(rx_data), 0);
    snap(); send_frame(8'h4B, 0, 1, -1, 0, 0, -1); settle();
    expect_out("R1 frame after mid-frame reset", 1, 0, 0, 8'h4B);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_ratios();
    t_sel_mid();
    t_parity();
    t_stop();
    t_vote();
    t_noise_start();
    t_back2back();
    t_reset_mid();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule